// File: doc/BRIEF.md
# SMI Software and Periodic Interval Timers

This block keeps two independent countdown timers that request a system management interrupt. One is a short-interval software timer with four selectable periods between 1.5 ms and 64 ms. The other is a long-interval periodic timer with four selectable periods between 8 s and 64 s. Software controls both through a four-word register port. One word holds the two enable bits, one holds the two status flags, and two configuration words hold the rate selects.

An internal prescaler divides the clock into microsecond ticks, and the timers count those ticks. When a timer reaches the end of its period it sets its status flag and raises a one-cycle `smi_o` pulse. If its enable bit is still set, it then starts another full period at once. Any write to the enable word or to either configuration word restarts every enabled timer from that moment, using the rate select in force after the write.

Top module: `smi_timer_unit`

## Requirements
- R1: After reset, all four register words read zero, both timers are idle and `smi_o` is low.
- R2: The port decodes word address 0 as enable, 1 as status, 2 as software rate config and 3 as periodic rate config. The software timer uses bit 6 of the enable and status words and the periodic timer uses bit 14. Reads return the stored fields at their bit positions, with every other bit zero.
- R3: A software rate select of 0 (config bits 7:6) gives a period of 1.5 ms, that is 1.5 × TICKS_PER_MS ticks.
- R4: Software rate selects 1, 2 and 3 give 8 × 2^sel ms (16, 32, 64 ms).
- R5: The periodic rate select (config bits 1:0) gives 8 × 2^(3−sel) s, so 0→64 s, 1→32 s, 2→16 s, 3→8 s.
- R6: On expiry the timer's status flag reads 1 and `smi_o` is high for exactly one cycle. Both appear on the clock edge after the expiring tick.
- R7: While its enable bit stays set, a timer expires again every full period, with no gap.
- R8: Clearing a timer's enable bit cancels its pending expiry, and no further pulse follows.
- R9: A write to the enable word or to either config word restarts every enabled timer with a full period counted from that write, using the newly written rate select.
- R10: A status write sets bits 6 and 14 to the written values. All other status bits stay zero.
- R11: If both timers expire on the same tick, a single `smi_o` pulse is produced and both status flags are set.
- R12: If an expiry and a status write happen on the same edge, the expiry's flag is set regardless of the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 2 | Word address of the register port |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data of the addressed word (combinational) |
| smi_o | output | 1 | One-cycle interrupt request pulse per expiry |

## Verification
The bound checker watches, on every cycle:
- that each internal expiry event becomes an `smi_o` pulse on the next edge and sets its own status flag;
- that every pulse has such a cause;
- that a status write without a coincident expiry leaves exactly the written bits 6 and 14;
- that no expiry occurs on a restarting write or right after an enable-clearing write.

Only the bench scenarios can show that the period lengths match the rate-select encodings, that re-arming has no gap and that a restart uses the new rate. The same holds for merging simultaneous expiries into one pulse and for an expiry winning over a status write on the same edge.

// File: rtl/smi_tmr_pkg.sv
package smi_tmr_pkg;

  localparam int unsigned DATA_W  = 32;
  localparam int unsigned ADDR_W  = 2;
  localparam int unsigned N_TMR   = 2;

  // timer index 0: software timer, index 1: periodic timer
  localparam int unsigned SW_BIT  = 6;
  localparam int unsigned PER_BIT = 14;

  localparam int unsigned SW_SEL_LSB  = 6;
  localparam int unsigned PER_SEL_LSB = 0;

  localparam logic [ADDR_W-1:0] A_EN     = 2'd0;
  localparam logic [ADDR_W-1:0] A_STS    = 2'd1;
  localparam logic [ADDR_W-1:0] A_SWCFG  = 2'd2;
  localparam logic [ADDR_W-1:0] A_PERCFG = 2'd3;

  // software timer period in ticks: 1.5 ms for select 0, else 8*2^sel ms
  function automatic logic [31:0] sw_ticks(input logic [1:0] sel,
                                           input int unsigned tpm);
    if (sel == 2'd0) return 32'((3 * tpm) / 2);
    return 32'((32'd8 << sel) * tpm);
  endfunction

  // periodic timer period in ticks: 8*2^(3-sel) seconds
  function automatic logic [31:0] per_ticks(input logic [1:0] sel,
                                            input int unsigned tpm,
                                            input int unsigned mps);
    return 32'((32'd8 << (2'd3 - sel)) * mps * tpm);
  endfunction

endpackage

// File: rtl/smi_tick_gen.sv
module smi_tick_gen #(
  parameter int unsigned CYC_PER_TICK = 250
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int unsigned CW = (CYC_PER_TICK > 1) ? $clog2(CYC_PER_TICK) : 1;
  localparam logic [CW-1:0] LAST = CW'(CYC_PER_TICK - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt == LAST) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/smi_countdown.sv
module smi_countdown #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             en,
  input  logic             restart,
  input  logic [CNT_W-1:0] period,
  output logic             expire
);
  logic [CNT_W-1:0] remain;
  logic             last_tick;

  assign last_tick = (remain <= CNT_W'(1));
  // a restarting write on the same edge wins over an expiry
  assign expire    = en & tick & ~restart & last_tick;

  always_ff @(posedge clk) begin
    if (!rst_n)            remain <= '0;
    else if (restart)      remain <= period;
    else if (en && tick)   remain <= last_tick ? period : remain - 1'b1;
  end
endmodule

// File: rtl/smi_regs.sv
module smi_regs
  import smi_tmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [N_TMR-1:0]  expire,
  output logic [N_TMR-1:0]  en_q,
  output logic [N_TMR-1:0]  sts_q,
  output logic [1:0]        sw_sel_nxt,
  output logic [1:0]        per_sel_nxt,
  output logic              restart,
  output logic [DATA_W-1:0] rd_data
);
  logic [1:0]       sw_sel_q, per_sel_q;
  logic             hit_en, hit_sts, hit_sw, hit_per;
  logic [N_TMR-1:0] en_nxt, sts_nxt, wr_pair;
  logic             unused_wr;

  assign unused_wr = ^wr_data;
  assign wr_pair   = {wr_data[PER_BIT], wr_data[SW_BIT]};

  always_comb begin
    hit_en      = wr_en && (addr == A_EN);
    hit_sts     = wr_en && (addr == A_STS);
    hit_sw      = wr_en && (addr == A_SWCFG);
    hit_per     = wr_en && (addr == A_PERCFG);
    restart     = hit_en | hit_sw | hit_per;
    en_nxt      = hit_en  ? wr_pair : en_q;
    sw_sel_nxt  = hit_sw  ? wr_data[SW_SEL_LSB +: 2]  : sw_sel_q;
    per_sel_nxt = hit_per ? wr_data[PER_SEL_LSB +: 2] : per_sel_q;
    // expiry flags are merged after the software value
    sts_nxt     = (hit_sts ? wr_pair : sts_q) | expire;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q      <= '0;
      sts_q     <= '0;
      sw_sel_q  <= '0;
      per_sel_q <= '0;
    end else begin
      en_q      <= en_nxt;
      sts_q     <= sts_nxt;
      sw_sel_q  <= sw_sel_nxt;
      per_sel_q <= per_sel_nxt;
    end
  end

  always_comb begin
    rd_data = '0;
    unique case (addr)
      A_EN:    begin rd_data[SW_BIT] = en_q[0];  rd_data[PER_BIT] = en_q[1];  end
      A_STS:   begin rd_data[SW_BIT] = sts_q[0]; rd_data[PER_BIT] = sts_q[1]; end
      A_SWCFG: rd_data[SW_SEL_LSB +: 2]  = sw_sel_q;
      default: rd_data[PER_SEL_LSB +: 2] = per_sel_q;
    endcase
  end
endmodule

// File: rtl/smi_timer_unit.sv
module smi_timer_unit
  import smi_tmr_pkg::*;
#(
  parameter int unsigned CYC_PER_TICK = 250,
  parameter int unsigned TICKS_PER_MS = 1000,
  parameter int unsigned MS_PER_SEC   = 1000,
  parameter int unsigned CNT_W        = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        addr,
  input  logic              wr_en,
  input  logic [31:0]       wr_data,
  output logic [31:0]       rd_data,
  output logic              smi_o
);
  logic             tick;
  logic [N_TMR-1:0] tmr_expire;
  logic [N_TMR-1:0] en_q, sts_q;
  logic [1:0]       sw_sel_nxt, per_sel_nxt;
  logic             restart;
  logic [CNT_W-1:0] period [N_TMR];

  smi_tick_gen #(.CYC_PER_TICK(CYC_PER_TICK)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  smi_regs u_regs (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .expire(tmr_expire), .en_q(en_q), .sts_q(sts_q),
    .sw_sel_nxt(sw_sel_nxt), .per_sel_nxt(per_sel_nxt),
    .restart(restart), .rd_data(rd_data)
  );

  assign period[0] = CNT_W'(sw_ticks(sw_sel_nxt, TICKS_PER_MS));
  assign period[1] = CNT_W'(per_ticks(per_sel_nxt, TICKS_PER_MS, MS_PER_SEC));

  for (genvar g = 0; g < N_TMR; g++) begin : g_tmr
    smi_countdown #(.CNT_W(CNT_W)) u_cd (
      .clk(clk), .rst_n(rst_n), .tick(tick), .en(en_q[g]),
      .restart(restart), .period(period[g]), .expire(tmr_expire[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) smi_o <= 1'b0;
    else        smi_o <= |tmr_expire;
  end
endmodule

// File: rtl/smi_timer_chk.sv
module smi_timer_chk
  import smi_tmr_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  addr,
  input logic        wr_en,
  input logic [31:0] wr_data,
  input logic        smi_o,
  input logic [1:0]  expire,
  input logic [1:0]  sts_q
);
  // R6
  expire_to_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expire != 2'b00) |=> smi_o);

  // R6
  pulse_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smi_o |-> ($past(expire) != 2'b00));

  // R12
  sw_flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire[0] |=> sts_q[0]);

  // R12
  per_flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire[1] |=> sts_q[1]);

  // R10
  sts_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_STS && expire == 2'b00) |=>
      (sts_q == {$past(wr_data[PER_BIT]), $past(wr_data[SW_BIT])}));

  // R9
  restart_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr != A_STS) |-> (expire == 2'b00));

  // R8
  sw_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_EN && !wr_data[SW_BIT]) |=> !expire[0]);

  // R8
  per_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_EN && !wr_data[PER_BIT]) |=> !expire[1]);
endmodule

bind smi_timer_unit smi_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
  .smi_o(smi_o), .expire(tmr_expire), .sts_q(sts_q)
);

// File: tb/tb_smi_timer_unit.sv
module tb_smi_timer_unit;
  localparam int C   = 2;
  localparam int TPM = 4;
  localparam int MPS = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        smi_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  smi_timer_unit #(.CYC_PER_TICK(C), .TICKS_PER_MS(TPM), .MS_PER_SEC(MPS)) dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .smi_o(smi_o)
  );

  // expected periods in ticks, written from the rate tables
  function automatic int sw_p(int sel);
    case (sel)
      0: return 1500 * TPM / 1000;
      1: return 16 * TPM;
      2: return 32 * TPM;
      default: return 64 * TPM;
    endcase
  endfunction
  function automatic int per_p(int sel);
    case (sel)
      0: return 64 * MPS * TPM;
      1: return 32 * MPS * TPM;
      2: return 16 * MPS * TPM;
      default: return 8 * MPS * TPM;
    endcase
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // called at a negedge; the write lands on the next posedge
  task automatic wr(logic [1:0] a, logic [31:0] d);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] d);
    addr = a;
    #1 d = rd_data;
  endtask

  // count edges until smi_o is seen, starting from the current negedge
  task automatic wait_pulse(int lim, output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!smi_o && n < lim);
  endtask

  task automatic count_pulses(int cycles, output int p);
    p = 0;
    repeat (cycles) begin @(negedge clk); if (smi_o) p++; end
  endtask

  task automatic check_window(int n, int per, string req);
    check(n >= (per - 1) * C + 1 && n <= per * C, req, n, per * C);
  endtask

  task automatic quiesce();
    wr(2'd0, 32'h0);
    wr(2'd1, 32'h0);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(4 * 190000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
      finish_up();
    end
  end

  initial begin
    logic [31:0] d;
    int n, p, sel;
    void'($urandom(32'd4242));

    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), d);
      check(d == 0, "R1 reset read", int'(d), 0);
    end
    check(smi_o == 0, "R1 smi idle", int'(smi_o), 0);

    // R2 read-back of stored fields
    wr(2'd3, 32'hFFFF_FFFE);
    rd(2'd3, d); check(d == 32'h2, "R2 percfg read", int'(d), 2);
    wr(2'd2, 32'hFFFF_FF7F);
    rd(2'd2, d); check(d == 32'h40, "R2 swcfg read", int'(d), 32'h40);
    wr(2'd0, 32'hFFFF_BFFF);
    rd(2'd0, d); check(d == 32'h40, "R2 enable read", int'(d), 32'h40);
    quiesce();

    // R3 software timer, select 0
    wr(2'd2, 32'h0);
    wr(2'd0, 32'h40);
    wait_pulse(1000, n);
    check_window(n, sw_p(0), "R3 1.5ms period");
    rd(2'd1, d); check(d == 32'h40, "R6 sw status", int'(d), 32'h40);
    @(negedge clk); check(smi_o == 0, "R6 one-cycle pulse", int'(smi_o), 0);
    // R7 back-to-back re-arm
    wait_pulse(1000, n);
    check(n == sw_p(0) * C - 1, "R7 re-arm gap", n, sw_p(0) * C - 1);
    // R12 expiry and status clear on the same edge
    repeat (sw_p(0) * C - 1) @(negedge clk);
    wr(2'd1, 32'h0);
    check(smi_o == 1, "R12 pulse on collision", int'(smi_o), 1);
    rd(2'd1, d); check(d == 32'h40, "R12 flag survives", int'(d), 32'h40);
    // R8 disable cancels
    wr(2'd0, 32'h0);
    count_pulses(4 * sw_p(0) * C, p);
    check(p == 0, "R8 cancel", p, 0);
    quiesce();

    // R4 random selects 1..3
    for (int t = 0; t < 4; t++) begin
      sel = 1 + int'($urandom % 3);
      wr(2'd2, 32'(sel) << 6);
      wr(2'd0, 32'h40);
      wait_pulse(2000, n);
      check_window(n, sw_p(sel), "R4 sw period");
      quiesce();
    end

    // R9 config write mid-period restarts with the new rate
    wr(2'd2, 32'hC0);
    wr(2'd0, 32'h40);
    repeat (100) @(negedge clk);
    wr(2'd2, 32'h40);
    wait_pulse(2000, n);
    check_window(n, sw_p(1), "R9 cfg restart");
    // R9 re-writing enable restarts the count
    repeat (60) @(negedge clk);
    wr(2'd0, 32'h40);
    wait_pulse(2000, n);
    check_window(n, sw_p(1), "R9 enable restart");
    quiesce();

    // R5 periodic timer
    for (int t = 0; t < 3; t++) begin
      sel = (t == 0) ? 0 : 2 + int'($urandom % 2);
      wr(2'd3, 32'(sel));
      wr(2'd0, 32'h4000);
      wait_pulse(10000, n);
      check_window(n, per_p(sel), "R5 periodic period");
      rd(2'd1, d); check(d == 32'h4000, "R5 periodic status", int'(d), 32'h4000);
      quiesce();
    end

    // R11 simultaneous expiry
    wr(2'd2, 32'hC0);
    wr(2'd3, 32'h3);
    wr(2'd0, 32'h4040);
    count_pulses(sw_p(3) * C + 4, p);
    check(p == 1, "R11 single pulse", p, 1);
    rd(2'd1, d); check(d == 32'h4040, "R11 both flags", int'(d), 32'h4040);
    quiesce();

    // R10 status write masking
    wr(2'd1, 32'hFFFF_FFFF);
    rd(2'd1, d); check(d == 32'h4040, "R10 set mask", int'(d), 32'h4040);
    wr(2'd1, 32'h0000_BFBF);
    rd(2'd1, d); check(d == 32'h0, "R10 clear", int'(d), 0);
    wr(2'd1, 32'h0000_0040);
    rd(2'd1, d); check(d == 32'h40, "R10 single bit", int'(d), 32'h40);

    done = 1;
    finish_up();
  end
endmodule